// File: doc/BRIEF.md
# Indexed Addressing Bus Cycle Sequencer

This block generates the data-phase bus cycles of an 8-bit processor's indexed memory operations on a 16-bit address space. Two addressing forms are handled. In absolute indexed form, the caller supplies a full base address and an index. In zero-page indirect indexed form, the caller supplies a page-zero pointer, and the block first fetches a 16-bit base from that pointer. The caller also selects an operation class: load, store or read-modify-write. The block then performs exactly one bus access per clock until the operation ends.

The block reproduces the known bus behaviour of such processors. The first indexed access goes to a provisional address. That address keeps the unmodified base high byte, and its low byte is the 8-bit sum of the base low byte and the index. A load takes this access as its real read when the low-byte sum produces no carry. If there is a carry, the load throws that data away and reads again at the corrected address. Stores and read-modify-write operations always perform the provisional access as a discarded read. A read-modify-write then reads the corrected location, writes the old value back, and finally writes the new value.

Opcode decode, the arithmetic of the modify step and processor flags are handled elsewhere. The new value of a read-modify-write arrives on an input. Memory is modelled as combinational read data that is valid in the same cycle as the address.

Top module: `idx_bus_seq`

## Requirements
- R1: While an operation runs, `bus_en_o` is high in every cycle and marks exactly one access per cycle. The number of accesses depends on the operation. An absolute load without carry takes 1 access and with carry takes 2. An absolute store takes 2. An absolute read-modify-write takes 4. Indirect mode adds 2 accesses in front of any of these.
- R2: The first access after the base is known is a read of {base[15:8], (base[7:0] + index) mod 256}. The index is 8-bit and zero-extended.
- R3: A load whose low-byte sum does not carry ends on that first access, and its data becomes the loaded value.
- R4: A load whose low-byte sum carries discards the first read and then reads (base + index) mod 65536. This includes wrap from page FF to page 00.
- R5: A store (`op_i` = 1) always reads the provisional address first, carry or not. It then writes `wdata_i` to (base + index) mod 65536. No operation begins with a write.
- R6: A read-modify-write (`op_i` = 2) makes four accesses in this order: a read of the provisional address, a read of the corrected address, a write of the value just read back to the corrected address, and a write of `mod_i` to the same address.
- R7: When `mode_i` = 1, the block first reads the pointer low byte at {00, ptr} and then the high byte at {00, (ptr + 1) mod 256}, where ptr = `base_i[7:0]`. The base used by the indexed accesses is {high byte, low byte}.
- R8: `load_o` changes only in the cycle after a completing load or read-modify-write. For a load it takes the data of the final read. For a read-modify-write it takes the old value of the corrected read. Discarded reads and stores leave it unchanged.
- R9: `done_o` is high for one cycle, in the cycle of the final access. The cycle after it is idle.
- R10: `start_i` is accepted only when idle. While an operation runs, `start_i` and all operand inputs are ignored. `op_i` code 0 is a load, and code 3 also behaves as a load.
- R11: After reset and whenever idle, `bus_en_o`, `bus_we_o` and `done_o` are low, and `load_o` resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an operation (accepted when idle) |
| mode_i | input | 1 | 0 absolute indexed, 1 zero-page indirect indexed |
| op_i | input | 2 | 0 load, 1 store, 2 read-modify-write, 3 load |
| base_i | input | 16 | Base address; low byte is the pointer in indirect mode |
| index_i | input | 8 | Index register value |
| wdata_i | input | 8 | Store data |
| mod_i | input | 8 | New value written by read-modify-write |
| bus_rdata_i | input | 8 | Read data for the current address |
| bus_addr_o | output | 16 | Access address |
| bus_en_o | output | 1 | An access takes place this cycle |
| bus_we_o | output | 1 | Access is a write |
| bus_wdata_o | output | 8 | Write data |
| done_o | output | 1 | Final access of the operation |
| load_o | output | 8 | Loaded value |

## Verification
The bench targets several corner cases, each with the failure it would expose. Loads whose low-byte sum just carries, and just fails to carry, show whether a design reads the fully summed address on the first access or skips the second read. Bases in page FF show whether the high-byte increment wraps to page 00. A pointer at FF shows whether its high-byte fetch wraps within page zero instead of spilling into page one. Stores and read-modify-writes without carry are checked for the dummy read that a design sharing the load path would drop. Every access's data is checked against `load_o`, so a load register that captures discarded reads is caught. A restart raised in the middle of an operation must not disturb its trace.

// File: rtl/idx_seq_pkg.sv
package idx_seq_pkg;

   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_WRITE = 2'd1,
      OP_RMW   = 2'd2,
      OP_RSVD  = 2'd3
   } op_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PTR_LO,
      ST_PTR_HI,
      ST_PRE,
      ST_FIX_RD,
      ST_STORE,
      ST_RMW_RD,
      ST_RMW_OLD,
      ST_RMW_NEW
   } st_e;

endpackage

// File: rtl/idx_addr_calc.sv
module idx_addr_calc #(
   parameter int DATA_W   = 8,
   parameter bit FULL_ADD = 1'b0,
   parameter int ADDR_W   = 2 * DATA_W
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [DATA_W-1:0] idx_i,
   output logic [ADDR_W-1:0] pre_addr_o,
   output logic [ADDR_W-1:0] fix_addr_o,
   output logic              carry_o
);

   logic [DATA_W:0] lo_sum;

   assign lo_sum     = {1'b0, base_i[DATA_W-1:0]} + {1'b0, idx_i};
   assign carry_o    = lo_sum[DATA_W];
   assign pre_addr_o = {base_i[ADDR_W-1:DATA_W], lo_sum[DATA_W-1:0]};

   generate
      if (FULL_ADD) begin : g_full_add
         assign fix_addr_o = base_i + {{DATA_W{1'b0}}, idx_i};
      end else begin : g_high_inc
         logic [DATA_W-1:0] hi_next;
         assign hi_next    = base_i[ADDR_W-1:DATA_W] + {{(DATA_W-1){1'b0}}, lo_sum[DATA_W]};
         assign fix_addr_o = {hi_next, lo_sum[DATA_W-1:0]};
      end
   endgenerate

endmodule

// File: rtl/idx_seq_fsm.sv
module idx_seq_fsm
   import idx_seq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic accept_i,
   input  logic ind_i,
   input  op_e  op_i,
   input  logic carry_i,
   output st_e  st_o,
   output logic done_o
);

   st_e  st_q, st_d;
   logic rd_cls;

   assign rd_cls = (op_i == OP_READ) || (op_i == OP_RSVD);

   always_comb begin
      st_d   = st_q;
      done_o = 1'b0;
      case (st_q)
         ST_IDLE:    if (accept_i) st_d = ind_i ? ST_PTR_LO : ST_PRE;
         ST_PTR_LO:  st_d = ST_PTR_HI;
         ST_PTR_HI:  st_d = ST_PRE;
         ST_PRE: begin
            if (op_i == OP_WRITE)    st_d = ST_STORE;
            else if (op_i == OP_RMW) st_d = ST_RMW_RD;
            else if (rd_cls && carry_i) st_d = ST_FIX_RD;
            else begin
               st_d   = ST_IDLE;
               done_o = 1'b1;
            end
         end
         ST_FIX_RD,
         ST_STORE,
         ST_RMW_NEW: begin
            st_d   = ST_IDLE;
            done_o = 1'b1;
         end
         ST_RMW_RD:  st_d = ST_RMW_OLD;
         ST_RMW_OLD: st_d = ST_RMW_NEW;
         default:    st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign st_o = st_q;

endmodule

// File: rtl/idx_op_regs.sv
module idx_op_regs
   import idx_seq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [DATA_W-1:0] idx_i,
   input  logic [1:0]        op_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [DATA_W-1:0] mod_i,
   input  st_e               st_i,
   input  logic [DATA_W-1:0] rdata_i,
   input  logic              done_i,
   output logic [ADDR_W-1:0] base_o,
   output logic [DATA_W-1:0] idx_o,
   output op_e               op_o,
   output logic [DATA_W-1:0] ptr_o,
   output logic [DATA_W-1:0] wd_o,
   output logic [DATA_W-1:0] md_o,
   output logic [DATA_W-1:0] old_o,
   output logic [DATA_W-1:0] load_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_o <= '0;
         idx_o  <= '0;
         op_o   <= OP_READ;
         ptr_o  <= '0;
         wd_o   <= '0;
         md_o   <= '0;
         old_o  <= '0;
         load_o <= '0;
      end else begin
         if (cap_i) begin
            base_o <= base_i;
            idx_o  <= idx_i;
            op_o   <= op_e'(op_i);
            ptr_o  <= base_i[DATA_W-1:0];
            wd_o   <= wdata_i;
            md_o   <= mod_i;
         end
         case (st_i)
            ST_PTR_LO: base_o[DATA_W-1:0]      <= rdata_i;
            ST_PTR_HI: base_o[ADDR_W-1:DATA_W] <= rdata_i;
            ST_RMW_RD: old_o                   <= rdata_i;
            default: ;
         endcase
         if (done_i) begin
            if (op_o == OP_RMW)        load_o <= old_o;
            else if (op_o != OP_WRITE) load_o <= rdata_i;
         end
      end
   end

endmodule

// File: rtl/idx_bus_seq.sv
module idx_bus_seq
   import idx_seq_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter bit HAS_INDIRECT = 1'b1,
   parameter bit FULL_ADD     = 1'b0,
   parameter int ADDR_W       = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              mode_i,
   input  logic [1:0]        op_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [DATA_W-1:0] index_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [DATA_W-1:0] mod_i,
   input  logic [DATA_W-1:0] bus_rdata_i,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic              bus_en_o,
   output logic              bus_we_o,
   output logic [DATA_W-1:0] bus_wdata_o,
   output logic              done_o,
   output logic [DATA_W-1:0] load_o
);

   localparam logic [DATA_W-1:0] ZP_PAGE = '0;
   localparam logic [DATA_W-1:0] ONE     = {{(DATA_W-1){1'b0}}, 1'b1};

   generate
      if (DATA_W < 4) begin : g_bad_width
         $error("idx_bus_seq: DATA_W must be at least 4");
      end
      if (ADDR_W != 2 * DATA_W) begin : g_bad_addr
         $error("idx_bus_seq: ADDR_W must be twice DATA_W");
      end
   endgenerate

   st_e               st;
   op_e               op_q;
   logic              accept, ind_eff, carry, done;
   logic [ADDR_W-1:0] base_q, pre_addr, fix_addr;
   logic [DATA_W-1:0] idx_q, ptr_q, wd_q, md_q, old_q;

   assign accept = start_i && (st == ST_IDLE);

   generate
      if (HAS_INDIRECT) begin : g_indirect
         assign ind_eff = mode_i;
      end else begin : g_abs_only
         assign ind_eff = 1'b0;
      end
   endgenerate

   idx_op_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_i   (accept),
      .base_i  (base_i),
      .idx_i   (index_i),
      .op_i    (op_i),
      .wdata_i (wdata_i),
      .mod_i   (mod_i),
      .st_i    (st),
      .rdata_i (bus_rdata_i),
      .done_i  (done),
      .base_o  (base_q),
      .idx_o   (idx_q),
      .op_o    (op_q),
      .ptr_o   (ptr_q),
      .wd_o    (wd_q),
      .md_o    (md_q),
      .old_o   (old_q),
      .load_o  (load_o)
   );

   idx_addr_calc #(.DATA_W(DATA_W), .FULL_ADD(FULL_ADD), .ADDR_W(ADDR_W)) addr_i (
      .base_i     (base_q),
      .idx_i      (idx_q),
      .pre_addr_o (pre_addr),
      .fix_addr_o (fix_addr),
      .carry_o    (carry)
   );

   idx_seq_fsm fsm_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept_i (accept),
      .ind_i    (ind_eff),
      .op_i     (op_q),
      .carry_i  (carry),
      .st_o     (st),
      .done_o   (done)
   );

   always_comb begin
      bus_addr_o  = '0;
      bus_we_o    = 1'b0;
      bus_wdata_o = '0;
      case (st)
         ST_IDLE:    bus_addr_o = '0;
         ST_PTR_LO:  bus_addr_o = {ZP_PAGE, ptr_q};
         ST_PTR_HI:  bus_addr_o = {ZP_PAGE, ptr_q + ONE};
         ST_PRE:     bus_addr_o = pre_addr;
         ST_STORE: begin
            bus_addr_o  = fix_addr;
            bus_we_o    = 1'b1;
            bus_wdata_o = wd_q;
         end
         ST_RMW_OLD: begin
            bus_addr_o  = fix_addr;
            bus_we_o    = 1'b1;
            bus_wdata_o = old_q;
         end
         ST_RMW_NEW: begin
            bus_addr_o  = fix_addr;
            bus_we_o    = 1'b1;
            bus_wdata_o = md_q;
         end
         default:    bus_addr_o = fix_addr;
      endcase
   end

   assign bus_en_o = (st != ST_IDLE);
   assign done_o   = done;

endmodule

// File: rtl/idx_bus_seq_chk.sv
module idx_bus_seq_chk #(
   parameter int DATA_W       = 8,
   parameter bit HAS_INDIRECT = 1'b1,
   parameter int ADDR_W       = 2 * DATA_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              mode_i,
   input logic [ADDR_W-1:0] base_i,
   input logic [DATA_W-1:0] index_i,
   input logic [ADDR_W-1:0] bus_addr_o,
   input logic              bus_en_o,
   input logic              bus_we_o,
   input logic              done_o,
   input logic [DATA_W-1:0] load_o
);

   localparam logic [DATA_W-1:0] ZP_PAGE = '0;

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_en_o |-> (!bus_we_o && !done_o));

   assert_no_write_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_en_o) |-> !bus_we_o);

   assert_pre_address_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(start_i && !bus_en_o && (!mode_i || !HAS_INDIRECT)))
      |-> (bus_en_o && !bus_we_o &&
           bus_addr_o == {$past(base_i[ADDR_W-1:DATA_W]),
                          $past(base_i[DATA_W-1:0] + index_i)}));

   assert_ptr_zero_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(start_i && !bus_en_o && mode_i) && HAS_INDIRECT)
      |-> (bus_addr_o[ADDR_W-1:DATA_W] == ZP_PAGE &&
           bus_addr_o[DATA_W-1:0] == $past(base_i[DATA_W-1:0])));

   assert_done_then_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!bus_en_o && !done_o));

   assert_load_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(load_o) |-> $past(done_o));

   assert_double_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we_o && $past(bus_we_o)) |-> (bus_addr_o == $past(bus_addr_o)));

endmodule

bind idx_bus_seq idx_bus_seq_chk #(
   .DATA_W       (DATA_W),
   .HAS_INDIRECT (HAS_INDIRECT),
   .ADDR_W       (ADDR_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .mode_i     (mode_i),
   .base_i     (base_i),
   .index_i    (index_i),
   .bus_addr_o (bus_addr_o),
   .bus_en_o   (bus_en_o),
   .bus_we_o   (bus_we_o),
   .done_o     (done_o),
   .load_o     (load_o)
);

// File: tb/idx_bus_seq_tb_top.sv
`timescale 1ns/1ps
module idx_bus_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        mode_i = 1'b0;
   logic [1:0]  op_i = 2'd0;
   logic [15:0] base_i = '0;
   logic [7:0]  index_i = '0;
   logic [7:0]  wdata_i = '0;
   logic [7:0]  mod_i = '0;
   logic [7:0]  bus_rdata_i;
   logic [15:0] bus_addr_o;
   logic        bus_en_o, bus_we_o, done_o;
   logic [7:0]  bus_wdata_o, load_o;

   logic [7:0]  zp_mem [256];
   int          n_chk = 0;
   int          n_fail = 0;
   logic [7:0]  exp_load = 8'h00;
   bit          finished = 1'b0;

   always #2.5 clk = ~clk;

   idx_bus_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .op_i(op_i),
      .base_i(base_i), .index_i(index_i), .wdata_i(wdata_i), .mod_i(mod_i),
      .bus_rdata_i(bus_rdata_i), .bus_addr_o(bus_addr_o), .bus_en_o(bus_en_o),
      .bus_we_o(bus_we_o), .bus_wdata_o(bus_wdata_o), .done_o(done_o), .load_o(load_o)
   );

   function automatic logic [7:0] memval(input logic [15:0] a);
      if (a[15:8] == 8'h00) return zp_mem[a[7:0]];
      return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'hA5;
   endfunction

   always_comb bus_rdata_i = memval(bus_addr_o);

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic run_op(input bit ind, input logic [1:0] op, input logic [15:0] base,
                         input logic [7:0] idx, input logic [7:0] wd, input logic [7:0] md,
                         input bit noisy);
      logic [15:0] ea [8];
      logic        ew [8];
      logic [7:0]  ed [8];
      string       er [8];
      int          en = 0;
      int          got = 0;
      int          done_at = -1;
      bit          load_steady = 1'b1;
      logic [15:0] b, pre, fix;
      logic        cy;
      logic [7:0]  el;
      el = exp_load;
      b  = base;
      if (ind) begin
         ea[0] = {8'h00, base[7:0]};         ew[0] = 0; ed[0] = 0; er[0] = "R7";
         ea[1] = {8'h00, base[7:0] + 8'd1};  ew[1] = 0; ed[1] = 0; er[1] = "R7";
         b  = {memval(ea[1]), memval(ea[0])};
         en = 2;
      end
      pre = {b[15:8], b[7:0] + idx};
      fix = b + {8'h00, idx};
      cy  = ({1'b0, b[7:0]} + {1'b0, idx}) > 9'h0ff;
      ea[en] = pre; ew[en] = 0; ed[en] = 0; er[en] = "R2"; en++;
      if (op == 2'd1) begin
         ea[en] = fix; ew[en] = 1; ed[en] = wd; er[en] = "R5"; en++;
      end else if (op == 2'd2) begin
         ea[en] = fix; ew[en] = 0; ed[en] = 0;           er[en] = "R6"; en++;
         ea[en] = fix; ew[en] = 1; ed[en] = memval(fix); er[en] = "R6"; en++;
         ea[en] = fix; ew[en] = 1; ed[en] = md;          er[en] = "R6"; en++;
         el = memval(fix);
      end else if (cy) begin
         ea[en] = fix; ew[en] = 0; ed[en] = 0; er[en] = "R4"; en++;
         el = memval(fix);
      end else begin
         el = memval(pre);
         er[en-1] = "R3";
      end

      mode_i = ind; op_i = op; base_i = base; index_i = idx; wdata_i = wd; mod_i = md;
      start_i = 1'b1;
      @(negedge clk);
      if (!noisy) start_i = 1'b0;
      for (int k = 0; k < 10; k++) begin
         if (load_o !== exp_load) load_steady = 1'b0;
         if (!bus_en_o) break;
         if (k < en)
            chk(bus_addr_o === ea[k] && bus_we_o === ew[k] && (!ew[k] || bus_wdata_o === ed[k]),
                er[k], "access addr/we/data",
                {bus_addr_o, 7'd0, bus_we_o, bus_wdata_o}, {ea[k], 7'd0, ew[k], ed[k]});
         got++;
         if (done_o) begin
            done_at = k;
            break;
         end
         if (noisy) begin
            base_i = 16'($urandom); index_i = 8'($urandom);
            op_i = 2'($urandom); mode_i = 1'($urandom);
         end
         @(negedge clk);
      end
      start_i = 1'b0;
      chk(got == en, "R1", "access count", got, en);
      chk(done_at == en - 1, "R9", "done position", done_at, en - 1);
      chk(load_steady, "R8", "load held during operation", 0, 0);
      @(negedge clk);
      chk(!bus_en_o && !bus_we_o && !done_o, noisy ? "R10" : "R11", "idle after done",
          {bus_en_o, bus_we_o, done_o}, 0);
      chk(load_o === el, (op == 2'd1) ? "R8" : "R3", "loaded value", load_o, el);
      exp_load = el;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL R1 watchdog expired: actual 1 expected 0");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'h1d2c));
      for (int i = 0; i < 256; i++) zp_mem[i] = 8'($urandom);
      zp_mem[8'h40] = 8'hF0; zp_mem[8'h41] = 8'h12;
      zp_mem[8'hFF] = 8'hE0; zp_mem[8'h00] = 8'h33;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!bus_en_o && !bus_we_o && !done_o && load_o === 8'h00, "R11", "reset state",
          {bus_en_o, bus_we_o, done_o, load_o}, 0);
      repeat (2) @(negedge clk);
      chk(!bus_en_o, "R11", "idle without start", bus_en_o, 0);

      run_op(0, 2'd0, 16'h2000, 8'h22, 8'h00, 8'h00, 0);  // R3 no carry
      run_op(0, 2'd0, 16'h20E0, 8'h22, 8'h00, 8'h00, 0);  // R4 carry, dummy at 2002
      run_op(0, 2'd0, 16'h3FE0, 8'h22, 8'h00, 8'h00, 0);  // R4 carry into 4002
      run_op(0, 2'd0, 16'h20FF, 8'h00, 8'h00, 8'h00, 0);  // R3 edge, no carry
      run_op(0, 2'd0, 16'h20FF, 8'h01, 8'h00, 8'h00, 0);  // R4 edge, carry
      run_op(0, 2'd0, 16'hFFF0, 8'h20, 8'h00, 8'h00, 0);  // R4 wrap to page 00
      run_op(0, 2'd3, 16'h3000, 8'h05, 8'h00, 8'h00, 0);  // R10 code 3 is load
      run_op(0, 2'd1, 16'h2000, 8'h10, 8'h5C, 8'h00, 0);  // R5 store no carry
      run_op(0, 2'd1, 16'h20F8, 8'h10, 8'hC5, 8'h00, 0);  // R5 store carry
      run_op(0, 2'd2, 16'h0246, 8'h03, 8'h00, 8'h9E, 0);  // R6 rmw no carry
      run_op(0, 2'd2, 16'h02F0, 8'h20, 8'h00, 8'h77, 0);  // R6 rmw carry
      run_op(1, 2'd0, 16'h0040, 8'h20, 8'h00, 8'h00, 0);  // R7 indirect, carry
      run_op(1, 2'd1, 16'h00FF, 8'h05, 8'hAB, 8'h00, 0);  // R7 pointer wraps in page zero
      run_op(1, 2'd2, 16'h0040, 8'h01, 8'h00, 8'h42, 0);  // R7 + R6
      run_op(0, 2'd0, 16'h20E0, 8'h22, 8'h00, 8'h00, 1);  // R10 restart ignored
      run_op(1, 2'd2, 16'h00FF, 8'hFF, 8'h00, 8'h11, 1);  // R10 restart ignored

      for (int n = 0; n < 600; n++)
         run_op(1'($urandom), 2'($urandom), 16'($urandom), 8'($urandom),
                8'($urandom), 8'($urandom), ($urandom % 8) == 0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule